// File: doc/BRIEF.md
# Ramping Digital Attenuator with Soft Mute

This block is a multi-channel digital volume stage for a 24-bit two's complement sample stream. Each channel holds a current attenuation level and walks it toward a target code one half-decibel step at a time. A step is taken once every eight valid samples, so the gain never jumps. Each output sample is the input multiplied by the linear gain of the current level, then rounded back to the sample width.

A per-channel mute request walks the level down to infinite attenuation at the same rate. Releasing mute walks it back up to the programmed code. A per-channel disable input zeroes the output at once. The gain values are computed from constants when the design is elaborated. Every channel ramps on its own, driven by the shared sample strobe.

Top module: `vol_ramp_att`

## Requirements
- R1: After reset every channel's level is code 255 (0 dB), `out_valid` is low, `out_data` is zero and `ramp_busy` is low while every `tgt_code` is 255.
- R2: A level code c in 129..255 applies the gain G(c) = round(2^GAIN_W · 10^((c−255)/40)) / 2^GAIN_W, that is 0.5·(c−255) dB. At code 255 the gain is exactly 1, and any sample passes through unchanged.
- R3: A target code in 0..128 is treated as infinite attenuation. Once the level reaches 128, every output sample of that channel is zero.
- R4: While the level differs from the effective target, it moves one code toward it on every eighth valid sample. The output for a sample uses the level held before that sample's update. `out_valid` and `out_data` appear one clock after the `in_valid` cycle.
- R5: With `mute` high, the effective target is code 128 and the level ramps down to it. When `mute` drops, the level ramps back up at the same rate to the channel's target code.
- R6: With `dis` high, the channel's output sample is zero. The level keeps ramping, and normal scaling resumes as soon as `dis` drops.
- R7: Channel k uses only `in_data[24k+23:24k]`, `tgt_code[8k+7:8k]`, `mute[k]` and `dis[k]`. A change on one channel has no effect on another channel's output or busy flag.
- R8: `ramp_busy[k]` is high exactly when channel k's level differs from its effective target. The effective target is 128 under mute or for a code of 128 or below, and the code itself otherwise.
- R9: The product is rounded half up, then saturated to the signed 24-bit range. For example, at code 254 an input of −1 yields −1.
- R10: The step timer counts only cycles with `in_valid` high. It is cleared whenever the level equals the effective target, and it restarts after each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a sample for all channels |
| in_data | input | NUM_CH*24 | Input samples, channel k at bits 24k+23:24k |
| tgt_code | input | NUM_CH*8 | Target attenuation codes, channel k at bits 8k+7:8k |
| mute | input | NUM_CH | Soft mute request per channel |
| dis | input | NUM_CH | Channel disable, forces zero output |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | NUM_CH*24 | Scaled samples, same packing as the input |
| ramp_busy | output | NUM_CH | Level differs from effective target |

## Verification
A wrong level or step timer shows up on the very next output sample as a value that is off by a full 0.5 dB ratio, or as a `ramp_busy` flag that disagrees with the reference. A timer that miscounts moves the whole staircase of output gains by one or more samples. The bench compares every sample of long ramps, including ones broken up by idle cycles, so such an offset appears within eight samples of a target, mute or disable change. Rounding faults show on small-magnitude and full-scale inputs at the first non-unity gain.

// File: rtl/att_pkg.sv
package att_pkg;
   localparam int CODE_W     = 8;
   localparam int NUM_STEPS  = 128;
   localparam logic [CODE_W-1:0] CODE_FULL  = 8'd255;
   localparam logic [CODE_W-1:0] CODE_FLOOR = 8'd128;

   // unsigned fixed-point gain with gw fraction bits for a level code
   function automatic longint att_gain(input int code, input int gw);
      real lin;
      lin = 10.0 ** ((real'(code) - 255.0) / 40.0);
      return longint'($rtoi(lin * (2.0 ** gw) + 0.5));
   endfunction
endpackage

// File: rtl/att_step_ctrl.sv
module att_step_ctrl #(
   parameter int STEP_SAMPLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp_vld,
   input  logic [7:0] tgt_code,
   input  logic       mute,
   output logic [7:0] level,
   output logic       busy
);
   localparam int TW = $clog2(STEP_SAMPLES);
   localparam logic [TW-1:0] T_LAST = TW'(STEP_SAMPLES - 1);

   logic [7:0]    level_q;
   logic [7:0]    eff;
   logic [TW-1:0] tmr_q;

   always_comb begin
      if (mute || tgt_code <= att_pkg::CODE_FLOOR) eff = att_pkg::CODE_FLOOR;
      else                                         eff = tgt_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= att_pkg::CODE_FULL;
         tmr_q   <= '0;
      end else if (level_q == eff) begin
         tmr_q <= '0;
      end else if (smp_vld) begin
         if (tmr_q == T_LAST) begin
            tmr_q   <= '0;
            level_q <= (level_q > eff) ? level_q - 8'd1 : level_q + 8'd1;
         end else begin
            tmr_q <= tmr_q + TW'(1);
         end
      end
   end

   assign level = level_q;
   assign busy  = (level_q != eff);

   a_r1_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      level_q >= att_pkg::CODE_FLOOR);

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != $past(level_q)) |->
         (level_q == $past(level_q) + 8'd1 || level_q == $past(level_q) - 8'd1));

   a_r10_step_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(level_q));

   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(level_q));
endmodule

// File: rtl/att_scale.sv
module att_scale #(
   parameter int DATA_W = 24,
   parameter int GAIN_W = 20
) (
   input  logic signed [DATA_W-1:0] samp,
   input  logic        [GAIN_W:0]   gain,
   output logic signed [DATA_W-1:0] res
);
   localparam int PW = DATA_W + GAIN_W + 2;
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GAIN_W - 1);
   localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DATA_W - 1)) - PW'(1);
   localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DATA_W - 1));

   logic signed [GAIN_W+1:0] g_s;
   logic signed [PW-1:0]     prod, shf;

   assign g_s  = $signed({1'b0, gain});
   assign prod = PW'(samp) * PW'(g_s);
   assign shf  = (prod + HALF) >>> GAIN_W;

   always_comb begin
      if (shf > MAXV)      res = DATA_W'(MAXV);
      else if (shf < MINV) res = DATA_W'(MINV);
      else                 res = shf[DATA_W-1:0];
   end
endmodule

// File: rtl/att_channel.sv
module att_channel #(
   parameter int DATA_W       = 24,
   parameter int GAIN_W       = 20,
   parameter int STEP_SAMPLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_smp,
   input  logic [7:0]        tgt_code,
   input  logic              mute,
   input  logic              dis,
   output logic [DATA_W-1:0] out_smp,
   output logic              busy
);
   logic [7:0]              level;
   logic [GAIN_W:0]         gtab [att_pkg::NUM_STEPS];
   logic signed [DATA_W-1:0] scaled;
   logic [DATA_W-1:0]       out_q;

   for (genvar i = 0; i < att_pkg::NUM_STEPS; i++) begin : g_rom
      assign gtab[i] = (GAIN_W+1)'(att_pkg::att_gain(i + att_pkg::NUM_STEPS, GAIN_W));
   end

   att_step_ctrl #(.STEP_SAMPLES(STEP_SAMPLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_vld(in_valid), .tgt_code(tgt_code),
      .mute(mute), .level(level), .busy(busy)
   );

   att_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .samp($signed(in_smp)), .gain(gtab[level[6:0]]), .res(scaled)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         out_q <= '0;
      else if (in_valid)
         out_q <= (dis || level == att_pkg::CODE_FLOOR) ? '0 : scaled;
   end

   assign out_smp = out_q;

   a_r6_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dis) |=> (out_q == '0));

   a_r3_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && level == att_pkg::CODE_FLOOR) |=> (out_q == '0));
endmodule

// File: rtl/vol_ramp_att.sv
module vol_ramp_att #(
   parameter int NUM_CH       = 2,
   parameter int DATA_W       = 24,
   parameter int GAIN_W       = 20,
   parameter int STEP_SAMPLES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [NUM_CH*DATA_W-1:0] in_data,
   input  logic [NUM_CH*8-1:0]      tgt_code,
   input  logic [NUM_CH-1:0]        mute,
   input  logic [NUM_CH-1:0]        dis,
   output logic                     out_valid,
   output logic [NUM_CH*DATA_W-1:0] out_data,
   output logic [NUM_CH-1:0]        ramp_busy
);
   if (NUM_CH < 1)                   $error("NUM_CH must be at least 1");
   if (DATA_W < 8 || DATA_W > 32)    $error("DATA_W out of range");
   if (GAIN_W < 12 || GAIN_W > 30)   $error("GAIN_W out of range");
   if (STEP_SAMPLES < 2)             $error("STEP_SAMPLES must be at least 2");

   logic vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= in_valid;
   end
   assign out_valid = vld_q;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      att_channel #(
         .DATA_W(DATA_W), .GAIN_W(GAIN_W), .STEP_SAMPLES(STEP_SAMPLES)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
         .in_smp(in_data[k*DATA_W +: DATA_W]),
         .tgt_code(tgt_code[k*8 +: 8]),
         .mute(mute[k]), .dis(dis[k]),
         .out_smp(out_data[k*DATA_W +: DATA_W]),
         .busy(ramp_busy[k])
      );
   end

   a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
endmodule

// File: tb/tb_vol_ramp_att.sv
module tb_vol_ramp_att;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2;
   localparam int DW  = 24;
   localparam int GW  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [NCH*DW-1:0] in_data = '0;
   logic [NCH*8-1:0]  tgt_code = {NCH{8'd255}};
   logic [NCH-1:0]    mute = '0;
   logic [NCH-1:0]    dis = '0;
   logic              out_valid;
   logic [NCH*DW-1:0] out_data;
   logic [NCH-1:0]    ramp_busy;

   int n_chk = 0, n_fail = 0;
   int lvl [NCH];
   int tmr [NCH];
   longint sdat [NCH];
   int scnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vol_ramp_att #(.NUM_CH(NCH), .DATA_W(DW), .GAIN_W(GW), .STEP_SAMPLES(8)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .tgt_code(tgt_code), .mute(mute), .dis(dis), .out_valid(out_valid),
      .out_data(out_data), .ramp_busy(ramp_busy)
   );

   function automatic int eff_of(int ch);
      int t = int'(tgt_code[ch*8 +: 8]);
      if (mute[ch] || t <= 128) return 128;
      return t;
   endfunction

   function automatic longint exp_out(int ch);
      longint g, p, r, mx, mn;
      if (dis[ch] || lvl[ch] == 128) return 0;
      g  = longint'($rtoi((10.0 ** ((real'(lvl[ch]) - 255.0) / 40.0)) * (2.0 ** GW) + 0.5));
      p  = sdat[ch] * g;
      r  = (p + (64'sd1 <<< (GW - 1))) >>> GW;
      mx = (64'sd1 <<< (DW - 1)) - 1;
      mn = -(64'sd1 <<< (DW - 1));
      if (r > mx) r = mx;
      if (r < mn) r = mn;
      return r;
   endfunction

   task automatic check(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cyc(bit v, string tag);
      longint e [NCH];
      in_valid = v;
      for (int ch = 0; ch < NCH; ch++) begin
         in_data[ch*DW +: DW] = sdat[ch][DW-1:0];
         e[ch] = exp_out(ch);
      end
      @(posedge clk);
      for (int ch = 0; ch < NCH; ch++) begin
         int ef = eff_of(ch);
         if (lvl[ch] == ef) tmr[ch] = 0;
         else if (v) begin
            if (tmr[ch] == 7) begin
               tmr[ch] = 0;
               lvl[ch] = (lvl[ch] > ef) ? lvl[ch] - 1 : lvl[ch] + 1;
            end else tmr[ch]++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, "out_valid", longint'(out_valid), longint'(v));
      for (int ch = 0; ch < NCH; ch++) begin
         if (v) check(tag, $sformatf("ch%0d data", ch),
                      longint'($signed(out_data[ch*DW +: DW])), e[ch]);
         check("R8", $sformatf("ch%0d busy", ch), longint'(ramp_busy[ch]),
               longint'(lvl[ch] != eff_of(ch)));
      end
   endtask

   function automatic longint pat(int n);
      logic [31:0] h;
      case (n % 16)
         0: return 64'sd8388607;
         1: return -64'sd8388608;
         2: return 64'sd1;
         3: return -64'sd1;
         default: begin
            h = 32'(n) * 32'h9E3779B1;
            return longint'($signed(h[23:0]));
         end
      endcase
   endfunction

   task automatic run(int nsmp, int gap, string tag);
      for (int k = 0; k < nsmp; k++) begin
         for (int ch = 0; ch < NCH; ch++) sdat[ch] = pat(scnt * 2 + ch + 3 * ch);
         scnt++;
         cyc(1'b1, tag);
         for (int j = 0; j < gap; j++) cyc(1'b0, tag);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      for (int ch = 0; ch < NCH; ch++) begin lvl[ch] = 255; tmr[ch] = 0; sdat[ch] = 0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", "out_valid", longint'(out_valid), 0);
      check("R1", "out_data", longint'(out_data), 0);
      check("R1", "busy", longint'(ramp_busy), 0);
      // R2: unity gain passthrough across patterns
      run(40, 0, "R2");
      // R4: single step then settle
      tgt_code[7:0] = 8'd254;
      run(20, 0, "R4");
      // R9: rounding at code 254 with small and extreme inputs
      for (int k = 0; k < 8; k++) begin
         sdat[0] = (k % 2) ? -longint'(k) : longint'(k);
         sdat[1] = -longint'(k);
         cyc(1'b1, "R9");
      end
      // R10: ramp with idle cycles between samples
      tgt_code[7:0] = 8'd248;
      run(70, 2, "R10");
      // R7: ch0 ramps to 129, ch1 untouched
      tgt_code[7:0] = 8'd129;
      run(1000, 0, "R7");
      // R3: code below floor gives zero
      tgt_code[7:0] = 8'd5;
      run(30, 0, "R3");
      tgt_code[7:0] = 8'd200;
      run(600, 0, "R4");
      // R5: mute ch1 down and back up
      mute[1] = 1'b1;
      run(1040, 0, "R5");
      mute[1] = 1'b0;
      run(1040, 0, "R5");
      // R6: disable ch0 while ramping, then release
      tgt_code[7:0] = 8'd230;
      dis[0] = 1'b1;
      run(100, 0, "R6");
      dis[0] = 1'b0;
      run(150, 1, "R6");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule